// File: doc/BRIEF.md
# Lockable Watchdog Timer

A 16-bit down-counter driven by a slow tick enable, which nominally arrives at 32.768 kHz. A prescaler divides the tick by 1, 16 or 256 before each count step. Software programs a load value and a control word. Setting the run bit gives a plain periodic timer that raises an interrupt each time the count passes zero. Setting the guard bit gives watchdog mode. In that mode, software must write the clear register before the count expires.

In watchdog mode, the action bit selects what an expiry does. It either emits a one-cycle reset request or latches an interrupt. Once the guard bit is accepted, the load and control registers ignore all writes. Only the block reset unlocks them and leaves watchdog mode. A full-scale load with the /256 prescaler gives a timeout of about 512 s.

Top module: `wdg_lock_timer`

## Requirements
- R1: After reset the value output reads 0xFFFF, the load and control outputs read 0, and both the interrupt and the reset request are low.
- R2: The counter changes only on a prescaled step while the run bit (control bit 7) or the guard bit (control bit 5) is set. A step decrements a non-zero count by one. With no step and no write, the count holds.
- R3: The prescale field, control bits 3:2, selects the divide ratio: 00 gives /1, 01 gives /16, 10 gives /256, and 11 also gives /256. Every accepted control write restarts the prescaler.
- R4: An accepted control write copies the load register into the counter in the same cycle. This includes the write that sets the guard bit.
- R5: While the guard bit is set, writes to the load register (select 0) and to the control register (select 1) are ignored.
- R6: A write of any data to the clear register (select 2) reloads the counter from the load register and restarts the prescaler.
- R7: A step that arrives at count 0 reloads the counter. Outside watchdog-reset mode it also sets the interrupt, which stays high until a clear write. A clear write and an expiry in the same cycle leave the interrupt low.
- R8: With the guard bit and the action bit (control bit 1) both set, an expiry drives the reset request high for exactly one cycle. The interrupt is not touched.
- R9: Only the block reset clears the guard bit. After that reset, the load and control registers accept writes again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Slow time-base enable, one clock wide per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 load, 1 control, 2 clear, 3 none |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| load_o | output | 16 | Load register contents |
| ctrl_o | output | 16 | Control register contents (unused bits read 0) |
| irq_o | output | 1 | Sticky timeout interrupt |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
A bad prescaler phase shows on count_o at the first step after a control or clear write. For example, a /16 setting that steps on tick 15 or 17 is visible after a single prescaled period. A lock flaw shows at load_o and ctrl_o in the cycle right after the ignored write. A wrong expiry decision shows one cycle after the step at zero, in one of three ways: the interrupt does not latch, the reset request lasts more than one cycle, or the wrong output fires for the configured action.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int unsigned CTRL_W   = 16;
   localparam int unsigned B_ACT    = 1;
   localparam int unsigned B_PS_LO  = 2;
   localparam int unsigned B_PS_HI  = 3;
   localparam int unsigned B_GUARD  = 5;
   localparam int unsigned B_RUN    = 7;
   localparam logic [CTRL_W-1:0] CTRL_MASK = 16'h00AE;

   typedef enum logic [1:0] {
      SEL_LOAD  = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_CLEAR = 2'd2,
      SEL_NONE  = 2'd3
   } wsel_e;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
   parameter int unsigned DIV_MID = 16,
   parameter int unsigned DIV_HI  = 256
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       restart_i,
   input  logic [1:0] sel_i,
   output logic       step_o
);
   localparam int unsigned PW = (DIV_HI > 2) ? $clog2(DIV_HI) : 1;

   if (DIV_MID < 2 || DIV_HI <= DIV_MID) begin : g_bad_div
      $error("wdg_prescale: need 2 <= DIV_MID < DIV_HI");
   end

   logic [PW-1:0] phase_q;
   logic [PW-1:0] limit;

   always_comb begin
      unique case (sel_i)
         2'b00:   limit = '0;
         2'b01:   limit = PW'(DIV_MID - 1);
         default: limit = PW'(DIV_HI - 1);
      endcase
   end

   assign step_o = tick_i && (phase_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            phase_q <= '0;
      else if (restart_i)    phase_q <= '0;
      else if (step_o)       phase_q <= '0;
      else if (tick_i)       phase_q <= phase_q + 1'b1;
   end
endmodule

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [1:0]        wr_sel_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   output logic [CNT_W-1:0]  load_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              reload_o,
   output logic              clear_o
);
   if (CNT_W < 2) begin : g_bad_w
      $error("wdg_regs: CNT_W too small");
   end

   logic locked;
   logic ctrl_take;
   logic load_take;

   assign locked    = ctrl_o[B_GUARD];
   assign load_take = wr_en_i && (wr_sel_i == SEL_LOAD) && !locked;
   assign ctrl_take = wr_en_i && (wr_sel_i == SEL_CTRL) && !locked;
   assign clear_o   = wr_en_i && (wr_sel_i == SEL_CLEAR);
   assign reload_o  = ctrl_take || clear_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_o <= '0;
         ctrl_o <= '0;
      end else begin
         if (load_take) load_o <= wr_data_i;
         if (ctrl_take) ctrl_o <= CTRL_W'(wr_data_i) & CTRL_MASK;
      end
   end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active_i,
   input  logic             step_i,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] load_i,
   output logic [CNT_W-1:0] count_o,
   output logic             expire_o
);
   assign expire_o = active_i && step_i && !reload_i && (count_o == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    count_o <= '1;
      else if (reload_i || expire_o) count_o <= load_i;
      else if (active_i && step_i)   count_o <= count_o - 1'b1;
   end
endmodule

// File: rtl/wdg_lock_timer.sv
module wdg_lock_timer
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned DIV_MID = 16,
   parameter int unsigned DIV_HI  = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] load_o,
   output logic [15:0]      ctrl_o,
   output logic             irq_o,
   output logic             rst_req_o
);
   logic reload, clear, step, expire, active, hard_mode;

   wdg_regs #(.CNT_W(CNT_W)) u_regs (
      .clk, .rst_n, .wr_en_i, .wr_sel_i, .wr_data_i,
      .load_o, .ctrl_o, .reload_o(reload), .clear_o(clear)
   );

   wdg_prescale #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_pre (
      .clk, .rst_n, .tick_i, .restart_i(reload),
      .sel_i(ctrl_o[B_PS_HI:B_PS_LO]), .step_o(step)
   );

   assign active    = ctrl_o[B_RUN] || ctrl_o[B_GUARD];
   assign hard_mode = ctrl_o[B_GUARD] && ctrl_o[B_ACT];

   wdg_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk, .rst_n, .active_i(active), .step_i(step), .reload_i(reload),
      .load_i(load_o), .count_o, .expire_o(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o     <= 1'b0;
         rst_req_o <= 1'b0;
      end else begin
         rst_req_o <= expire && hard_mode;
         if (clear)                    irq_o <= 1'b0;
         else if (expire && !hard_mode) irq_o <= 1'b1;
      end
   end
endmodule

// File: rtl/wdg_lock_timer_chk.sv
module wdg_lock_timer_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             wr_en_i,
   input logic [1:0]       wr_sel_i,
   input logic [CNT_W-1:0] count_o,
   input logic [CNT_W-1:0] load_o,
   input logic [15:0]      ctrl_o,
   input logic             irq_o,
   input logic             rst_req_o
);
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !wr_en_i) |=> $stable(count_o)); // R2
   AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_o[5] |=> ($stable(load_o) && $stable(ctrl_o))); // R5
   AST_CLEAR_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_sel_i == 2'd2) |=> (count_o == $past(load_o))); // R6
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !(wr_en_i && wr_sel_i == 2'd2)) |=> irq_o); // R7
   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o); // R8
   AST_RST_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |-> (ctrl_o[5] && ctrl_o[1])); // R8
endmodule

bind wdg_lock_timer wdg_lock_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk, .rst_n, .tick_i, .wr_en_i, .wr_sel_i,
   .count_o, .load_o, .ctrl_o, .irq_o, .rst_req_o
);

// File: tb/wdg_lock_timer_test.sv
module wdg_lock_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_sel_i = 2'd3;
   logic [15:0] wr_data_i = '0;
   logic [15:0] count_o, load_o, ctrl_o;
   logic        irq_o, rst_req_o;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   wdg_lock_timer uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0; wr_sel_i = 2'd3;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_reset();
      chk("R1 count", count_o, 32'hFFFF);
      chk("R1 load", load_o, 0);
      chk("R1 ctrl", ctrl_o, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 rstreq", rst_req_o, 0);
   endtask

   task automatic t_normal();
      wr(2'd0, 16'd5);
      ticks(3);
      chk("R2 idle without run bit", count_o, 32'hFFFF);
      wr(2'd1, 16'h0080);
      chk("R4 load on ctrl write", count_o, 5);
      ticks(2);
      chk("R2 two steps", count_o, 3);
      repeat (4) @(negedge clk);
      chk("R2 hold no tick", count_o, 3);
      ticks(4);
      chk("R7 normal expiry reload", count_o, 5);
      chk("R7 normal expiry irq", irq_o, 1);
      wr(2'd2, 16'h1234);
      chk("R7 clear drops irq", irq_o, 0);
   endtask

   task automatic t_prescale();
      wr(2'd0, 16'd10);
      wr(2'd1, 16'h0084);
      ticks(15);
      chk("R3 /16 before", count_o, 10);
      ticks(1);
      chk("R3 /16 step", count_o, 9);
      wr(2'd1, 16'h0088);
      ticks(255);
      chk("R3 /256 before", count_o, 10);
      ticks(1);
      chk("R3 /256 step", count_o, 9);
      wr(2'd1, 16'h008C);
      ticks(255);
      chk("R3 code11 before", count_o, 10);
      ticks(1);
      chk("R3 code11 step", count_o, 9);
   endtask

   task automatic t_guard_irq();
      wr(2'd0, 16'd7);
      wr(2'd1, 16'h0020);
      chk("R4 guard entry load", count_o, 7);
      wr(2'd0, 16'd100);
      chk("R5 load locked", load_o, 7);
      wr(2'd1, 16'h0000);
      chk("R5 ctrl locked", ctrl_o, 32'h0020);
      ticks(3);
      chk("R6 pre clear", count_o, 4);
      wr(2'd2, 16'h0);
      chk("R6 clear reload", count_o, 7);
      ticks(8);
      chk("R7 guard irq", irq_o, 1);
      chk("R7 guard reload", count_o, 7);
      chk("R8 no reset in irq mode", rst_req_o, 0);
      ticks(3);
      chk("R7 irq sticky", irq_o, 1);
      wr(2'd2, 16'h0);
      chk("R7 irq cleared", irq_o, 0);
   endtask

   task automatic t_guard_reset();
      do_reset();
      chk("R9 guard released", ctrl_o, 0);
      wr(2'd0, 16'd2);
      chk("R9 load writable", load_o, 2);
      wr(2'd1, 16'h0022);
      ticks(2);
      chk("R8 before expiry", rst_req_o, 0);
      ticks(1);
      chk("R8 pulse high", rst_req_o, 1);
      chk("R8 irq untouched", irq_o, 0);
      @(negedge clk);
      chk("R8 pulse one cycle", rst_req_o, 0);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            t_reset();
            t_normal();
            t_prescale();
            do_reset();
            t_guard_irq();
            t_guard_reset();
            done = 1'b1;
         end
         begin
            repeat (100000) @(negedge clk);
            if (!done) begin
               n_run++; n_fail++;
               $display("FAIL watchdog actual=hung expected=done");
            end
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule